// File: doc/BRIEF.md
# Five-Operand Bit-Serial Adder

The block adds five unsigned words that arrive one bit per clock, least significant bit first, each on its own one-bit line. It returns their sum as a single bit-serial stream.

Four serial full-adder stages form a chain:

- The first stage adds operand 0 and operand 1.
- Each later stage adds one more operand to the sum stream of the stage before it.
- Every stage keeps its carry in a flip-flop and feeds it back as carry-in on the next bit time.

A start-of-word strobe marks the first bit of each word. It makes every stage take its first bit with a carry-in of zero, so carries from earlier traffic never leak into a new word.

The parameter `PIPELINED` selects one of two forms:

- When it is 0, the four stages form one combinational chain. The sum bit appears in the same cycle as the operand bits, and the clock period must cover four full-adder delays.
- When it is 1, each stage's sum bit is registered before the next stage uses it. The operand and strobe lines feeding stage k are delayed by k cycles to match. The sum then lags the inputs by four cycles, and the critical path is a single full adder.

A small word controller has two states:

- IDLE: no word is in flight.
- RUN: a word is in progress and a count of its remaining bits is kept.

Its transitions are:

- IDLE to RUN on the strobe.
- RUN to RUN while bits remain, or when the strobe restarts a word.
- RUN to IDLE after the last bit.

The controller's activity flag, delayed by the form's latency, becomes the sum-valid output. The sum is kept to `WORD_W` bits, and anything past that width is dropped.

Top module: `serial_sum5`

## Requirements
- R1: A synchronous reset clears all carries, pipeline registers and the controller. In the first cycle after the reset edge `sum_vld` is 0, and in the pipelined form `sum_bit` is 0.
- R2: Over a word, the `WORD_W` bits on `sum_bit` (least significant first) equal the sum of the five operand words modulo 2^WORD_W. Each stage computes its sum bit as a xor b xor carry-in, and its carry-out is 1 when at least two of the three inputs are 1.
- R3: The bit presented with `word_start` high is added with every stage carry-in forced to 0. A word sent directly after another, with no idle cycle, is summed with no carry from the previous word.
- R4: With `PIPELINED` = 0, sum bit i appears in the same clock cycle as operand bit i.
- R5: With `PIPELINED` = 1, sum bit i appears exactly four clock cycles after operand bit i.
- R6: `sum_vld` is high for exactly `WORD_W` consecutive cycles for each word, starting at the first sum bit, and is low afterwards until the next word.
- R7: Carries beyond bit `WORD_W`-1 are discarded. Five all-ones operands yield 5*(2^WORD_W - 1) modulo 2^WORD_W.
- R8: `word_start` raised while a word is in progress abandons that word and begins a new one from bit 0. `sum_vld` stays high without a gap for a further `WORD_W` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_start | input | 1 | High on the cycle that carries bit 0 of a word |
| op_bit | input | 5 | Current bit of operands 4..0, bit k belongs to operand k |
| sum_bit | output | 1 | Current bit of the serial sum |
| sum_vld | output | 1 | High while `sum_bit` carries a bit of a word's sum |

## Verification
Both forms are built side by side and fed the same stimulus. Every check therefore compares a zero-latency stream with a four-cycle-lagged one.

Each input pattern targets a different fault:

- All-zero words and a lone value on operand 0 show whether the chain passes data through.
- A value only on operand 4 shows whether the deepest operand line is delayed correctly in the pipelined form.
- A mixed pattern exercises carries in every stage.
- All-ones operands exercise overflow.
- An all-ones word followed at once by a word whose sum is 1 shows whether the start strobe clears carries.
- A strobe raised mid-word shows whether the controller and the carry clear restart cleanly.

// File: rtl/serial_sum5_pkg.sv
package serial_sum5_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wctl_state_e;

    localparam int NUM_OPS  = 5;
    localparam int NUM_STGS = NUM_OPS - 1;
endpackage

// File: rtl/bit_delay.sv
module bit_delay #(
    parameter int DEPTH = 1,
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_regs
            logic [DEPTH-1:0][WIDTH-1:0] sr_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr_q <= '0;
                end else begin
                    sr_q[0] <= d_i;
                    for (int j = 1; j < DEPTH; j++) begin
                        sr_q[j] <= sr_q[j-1];
                    end
                end
            end
            assign q_o = sr_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/serial_fa_stage.sv
module serial_fa_stage #(
    parameter bit REG_SUM = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic a_i,
    input  logic b_i,
    output logic sum_o
);
    logic carry_q;
    logic cin_eff;
    logic s_comb;
    logic co_comb;

    always_comb begin
        cin_eff = clr_i ? 1'b0 : carry_q;
        s_comb  = a_i ^ b_i ^ cin_eff;
        co_comb = (a_i & b_i) | (a_i & cin_eff) | (b_i & cin_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) carry_q <= 1'b0;
        else     carry_q <= co_comb;
    end

    generate
        if (REG_SUM) begin : g_reg
            logic sum_q;
            always_ff @(posedge clk) begin
                if (rst) sum_q <= 1'b0;
                else     sum_q <= s_comb;
            end
            assign sum_o = sum_q;
        end else begin : g_comb
            assign sum_o = s_comb;
        end
    endgenerate

    // R3
    carry_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !(a_i && b_i)) |=> !carry_q);
endmodule

// File: rtl/word_ctrl.sv
module word_ctrl
    import serial_sum5_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic active_o
);
    localparam int CW = $clog2(WORD_W + 1);

    wctl_state_e     state_q, state_n;
    logic [CW-1:0]   remain_q, remain_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_n;
            remain_q <= remain_n;
        end
    end

    always_comb begin
        state_n  = state_q;
        remain_n = remain_q;
        active_o = 1'b0;
        if (start_i) begin
            active_o = 1'b1;
            remain_n = CW'(WORD_W - 1);
            state_n  = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    remain_n = '0;
                end
                ST_RUN: begin
                    active_o = 1'b1;
                    remain_n = remain_q - 1'b1;
                    if (remain_q == CW'(1)) state_n = ST_IDLE;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // R6
    last_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && remain_q == CW'(1) && !start_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/serial_sum5.sv
module serial_sum5
    import serial_sum5_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter bit PIPELINED = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                word_start,
    input  logic [NUM_OPS-1:0]  op_bit,
    output logic                sum_bit,
    output logic                sum_vld
);
    localparam int LAT = PIPELINED ? NUM_STGS : 0;

    logic [NUM_STGS:0]   chain;
    logic [NUM_STGS-1:0] stg_clr;
    logic [NUM_STGS-1:0] stg_b;
    logic                word_act;

    assign chain[0] = op_bit[0];

    genvar k;
    generate
        for (k = 0; k < NUM_STGS; k++) begin : g_stg
            bit_delay #(
                .DEPTH (PIPELINED ? k : 0),
                .WIDTH (2)
            ) u_align (
                .clk (clk),
                .rst (rst),
                .d_i ({word_start, op_bit[k+1]}),
                .q_o ({stg_clr[k], stg_b[k]})
            );
            serial_fa_stage #(
                .REG_SUM (PIPELINED)
            ) u_fa (
                .clk   (clk),
                .rst   (rst),
                .clr_i (stg_clr[k]),
                .a_i   (chain[k]),
                .b_i   (stg_b[k]),
                .sum_o (chain[k+1])
            );
        end
    endgenerate

    word_ctrl #(
        .WORD_W (WORD_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (word_start),
        .active_o (word_act)
    );

    bit_delay #(
        .DEPTH (LAT),
        .WIDTH (1)
    ) u_vdly (
        .clk (clk),
        .rst (rst),
        .d_i (word_act),
        .q_o (sum_vld)
    );

    assign sum_bit = chain[NUM_STGS];

    generate
        if (PIPELINED) begin : g_pchk
            // R5
            pipe_lat_chk: assert property (@(posedge clk) disable iff (rst)
                word_start |-> ##4 sum_vld);
        end else begin : g_cchk
            // R4
            comb_vld_chk: assert property (@(posedge clk) disable iff (rst)
                word_start |-> sum_vld);
        end
    endgenerate

    // R2
    sum_known_chk: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> !$isunknown(sum_bit));
endmodule

// File: tb/tb_serial_sum5.sv
module tb_serial_sum5;
    localparam int W    = 8;
    localparam int PL   = 4;
    localparam int CAPN = 128;
    typedef logic [W-1:0] word_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sow = 1'b0;
    logic [4:0] ops = '0;
    logic       sum_p, vld_p, sum_c, vld_c;

    serial_sum5 #(.WORD_W(W), .PIPELINED(1'b1)) dut (
        .clk(clk), .rst(rst), .word_start(sow), .op_bit(ops),
        .sum_bit(sum_p), .sum_vld(vld_p));

    serial_sum5 #(.WORD_W(W), .PIPELINED(1'b0)) dut_comb (
        .clk(clk), .rst(rst), .word_start(sow), .op_bit(ops),
        .sum_bit(sum_c), .sum_vld(vld_c));

    always #5 clk = ~clk;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    logic cap_sp [CAPN];
    logic cap_vp [CAPN];
    logic cap_sc [CAPN];
    logic cap_vc [CAPN];

    task automatic step(input logic s, input logic [4:0] b);
        @(negedge clk);
        sow = s;
        ops = b;
        #1;
        if (cyc < CAPN) begin
            cap_sp[cyc] = sum_p;
            cap_vp[cyc] = vld_p;
            cap_sc[cyc] = sum_c;
            cap_vc[cyc] = vld_c;
        end
        cyc++;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic word_t exp_sum(input word_t w[5]);
        int s = 0;
        for (int i = 0; i < 5; i++) s += int'(w[i]);
        return word_t'(s);
    endfunction

    task automatic send_bits(input word_t w[5], input int nbits);
        for (int i = 0; i < nbits; i++) begin
            step(i == 0, {w[4][i], w[3][i], w[2][i], w[1][i], w[0][i]});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 5'b0);
    endtask

    task automatic check_word(input string req, input int start, input word_t w[5]);
        word_t e = exp_sum(w);
        for (int i = 0; i < W; i++) begin
            chk(req, "comb sum bit", cap_sc[start+i], e[i]);
            chk(req, "comb sum_vld", cap_vc[start+i], 1'b1);
            chk(req, "pipe sum bit", cap_sp[start+PL+i], e[i]);
            chk(req, "pipe sum_vld", cap_vp[start+PL+i], 1'b1);
        end
    endtask

    task automatic check_quiet(input string req, input int idx);
        chk(req, "comb sum_vld after word", cap_vc[idx], 1'b0);
        chk(req, "pipe sum_vld after word", cap_vp[idx+PL], 1'b0);
    endtask

    // R1: reset state, then reset in the middle of a word
    task automatic test_reset();
        word_t w[5] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        cyc = 0;
        rst = 1'b1;
        idle(2);
        chk("R1", "comb sum_vld in reset", cap_vc[1], 1'b0);
        chk("R1", "pipe sum_vld in reset", cap_vp[1], 1'b0);
        chk("R1", "pipe sum_bit in reset", cap_sp[1], 1'b0);
        rst = 1'b0;
        idle(1);
        send_bits(w, 3);
        rst = 1'b1;
        idle(1);
        chk("R1", "comb sum_vld after reset edge", cap_vc[cyc-1], 1'b0);
        chk("R1", "pipe sum_vld after reset edge", cap_vp[cyc-1], 1'b0);
        chk("R1", "pipe sum_bit after reset edge", cap_sp[cyc-1], 1'b0);
        rst = 1'b0;
        idle(PL + 2);
    endtask

    // R2, R4, R5, R6 with several operand patterns
    task automatic test_patterns();
        word_t p0[5] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        word_t p1[5] = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
        word_t p2[5] = '{8'hA5, 8'h5A, 8'h0F, 8'hF0, 8'h33};
        word_t p3[5] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h81};
        int s0, s1, s2, s3;
        cyc = 0;
        idle(1);
        s0 = cyc; send_bits(p0, W); idle(2);
        s1 = cyc; send_bits(p1, W); idle(2);
        s2 = cyc; send_bits(p2, W); idle(2);
        s3 = cyc; send_bits(p3, W); idle(PL + 2);
        check_word("R2 R4 R5 zeros", s0, p0);
        check_word("R2 R4 R5 operand0 only", s1, p1);
        check_word("R2 R4 R5 mixed", s2, p2);
        check_word("R2 R4 R5 operand4 only", s3, p3);
        check_quiet("R6", s0 + W);
        check_quiet("R6", s2 + W);
        check_quiet("R6", s3 + W);
    endtask

    // R7: overflow discarded
    task automatic test_overflow();
        word_t p[5] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        int s;
        cyc = 0;
        idle(1);
        s = cyc; send_bits(p, W); idle(PL + 2);
        check_word("R7", s, p);
        check_quiet("R7 R6", s + W);
    endtask

    // R3: back-to-back words, carry must not leak
    task automatic test_back2back();
        word_t pa[5] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        word_t pb[5] = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
        int sa, sb;
        cyc = 0;
        idle(1);
        sa = cyc; send_bits(pa, W);
        sb = cyc; send_bits(pb, W); idle(PL + 2);
        check_word("R3 first", sa, pa);
        check_word("R3 second", sb, pb);
        check_quiet("R3 R6", sb + W);
    endtask

    // R8: strobe mid-word restarts
    task automatic test_restart();
        word_t pa[5] = '{8'hFF, 8'h7F, 8'h3C, 8'hFF, 8'h11};
        word_t pb[5] = '{8'h12, 8'h34, 8'h56, 8'h07, 8'h08};
        int sa, sb;
        cyc = 0;
        idle(1);
        sa = cyc; send_bits(pa, 3);
        sb = cyc; send_bits(pb, W); idle(PL + 2);
        for (int i = sa; i < sb; i++) begin
            chk("R8", "comb sum_vld before restart", cap_vc[i], 1'b1);
            chk("R8", "pipe sum_vld before restart", cap_vp[i+PL], 1'b1);
        end
        check_word("R8 restarted word", sb, pb);
        check_quiet("R8", sb + W);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_patterns();
        test_overflow();
        test_back2back();
        test_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule